// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block performs the control-register updates a small processor core makes in the single cycle when it takes an exception or an interrupt. The core supplies a one-cycle valid strobe and a 5-bit cause code. With them it supplies the present program counter, the live values of the status, saved-status, debug-saved-status, cause and translation-miscellaneous registers, the address that faulted, and two vector addresses: the general handler and the fast translation-miss handler. On the next clock edge the block registers the new values of all of those registers. It also holds its own exception-return address, break-return address and faulting-address registers, and loads them when the cause calls for it.

How much state is saved depends on the cause and on whether the core was already inside a handler, which the handler bit in status shows. A first translation miss takes a fast path with its own vector. A miss taken while that bit is already set is marked as a double miss and leaves the saved state alone. A break stores its state in a separate pair of registers. A cause code the block does not know raises an abort flag and changes nothing. Instruction decode, the pipeline flush and the return path belong to the surrounding core.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is held, and after it, every register output reads zero except `pc_o`, which reads `RESET_VEC`. `abort_o` reads 0.
- R2: In a cycle with `exc_valid_i` low, all outputs keep their values at the next edge and `abort_o` is 0.
- R3: Cause codes are: 1 interrupt, 2 translation miss, 3/4/5 read/write/execute permission fault, 6/7/8 supervisor address/instruction/data, 9 illegal instruction, 10 trap, 11 break, 12 misaligned access. For causes 1 to 11, `exc_o` equals the input cause register with bits 6:2 replaced by the cause code. Unless a requirement below says otherwise, `tlbmisc_o`, `estatus_o` and `bstatus_o` copy their inputs and `ea_o`, `ba_o` and `badaddr_o` hold.
- R4: Status bits are PIE=0, U=1, EH=2, IH=3. An interrupt (cause 1) sets `estatus_o` to the input status and sets IH in `status_o` while clearing PIE and U. It sets `ea_o` to PC+4 and `pc_o` to the general vector.
- R5: A translation miss with EH clear sets `estatus_o` to the input status. In `status_o` it sets EH and clears PIE and U. In `tlbmisc_o` it clears the double-miss bit (bit 1) and sets the write-flag bit (bit 0). It sets `ea_o` to PC+4 and `pc_o` to the fast-miss vector.
- R6: A translation miss with EH set keeps `estatus_o` equal to the input and holds `ea_o`. It sets EH and clears PIE and U in `status_o`, sets the double-miss bit in `tlbmisc_o`, and sets `pc_o` to the general vector.
- R7: A permission fault (causes 3 to 5) always sets `estatus_o` to the input status and `ea_o` to PC+4. It sets EH and clears PIE and U, and sets `pc_o` to the general vector.
- R8: Causes 6 to 10 set `estatus_o` and `ea_o` only when EH was clear beforehand. They always set EH, clear PIE and U, and set `pc_o` to the general vector.
- R9: A break (cause 11) sets `bstatus_o` to the input status and `ba_o` to PC+4 only when EH was clear. It never changes `estatus_o` from the input or `ea_o` from its held value. It always sets EH, clears PIE and U, and sets `pc_o` to the general vector.
- R10: A misaligned access (cause 12) sets `badaddr_o` to `fault_addr_i` and sets `exc_o` to the cause code shifted left by 2, with every other bit zero. `pc_o` and the status registers copy their inputs.
- R11: Any other cause code with `exc_valid_i` high sets `abort_o` for one cycle, and every register output holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid_i | input | 1 | Exception-entry strobe |
| exc_cause_i | input | 5 | Cause code |
| cur_pc_i | input | XLEN | Program counter of the faulting instruction |
| cur_status_i | input | XLEN | Live status register |
| cur_estatus_i | input | XLEN | Live saved-status register |
| cur_bstatus_i | input | XLEN | Live debug-saved-status register |
| cur_exc_i | input | XLEN | Live cause register |
| cur_tlbmisc_i | input | XLEN | Live translation-miscellaneous register |
| fault_addr_i | input | XLEN | Faulting data address |
| gen_vector_i | input | XLEN | General exception vector |
| tlbmiss_vector_i | input | XLEN | Fast translation-miss vector |
| pc_o | output | XLEN | New program counter |
| status_o | output | XLEN | New status |
| estatus_o | output | XLEN | New saved status |
| bstatus_o | output | XLEN | New debug-saved status |
| exc_o | output | XLEN | New cause register |
| tlbmisc_o | output | XLEN | New translation-miscellaneous register |
| ea_o | output | XLEN | Exception-return address |
| ba_o | output | XLEN | Break-return address |
| badaddr_o | output | XLEN | Faulting-address register |
| abort_o | output | 1 | Unknown-cause flag |

## Verification
The bench builds the block with XLEN at 32 and overrides RESET_VEC with a non-zero value. A reset that is wrongly tied to zero, or a program counter that does not load from the parameter, then becomes visible. With 32-bit words the bench can plant marker bits above bit 6 in the cause register and above bit 1 in the miscellaneous register. Those markers show that only the cause field and the two flag bits are rewritten. Each cause class runs with EH both clear and set, which reaches the fast and double miss paths and both branches of the conditional save.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int CAUSE_W = 5;

  localparam logic [CAUSE_W-1:0] C_IRQ      = 5'd1;
  localparam logic [CAUSE_W-1:0] C_TMISS    = 5'd2;
  localparam logic [CAUSE_W-1:0] C_PERM_R   = 5'd3;
  localparam logic [CAUSE_W-1:0] C_PERM_W   = 5'd4;
  localparam logic [CAUSE_W-1:0] C_PERM_X   = 5'd5;
  localparam logic [CAUSE_W-1:0] C_SUP_A    = 5'd6;
  localparam logic [CAUSE_W-1:0] C_SUP_I    = 5'd7;
  localparam logic [CAUSE_W-1:0] C_SUP_D    = 5'd8;
  localparam logic [CAUSE_W-1:0] C_ILLEGAL  = 5'd9;
  localparam logic [CAUSE_W-1:0] C_TRAP     = 5'd10;
  localparam logic [CAUSE_W-1:0] C_BREAK    = 5'd11;
  localparam logic [CAUSE_W-1:0] C_MISALIGN = 5'd12;

  // status bit positions
  localparam int ST_PIE = 0;
  localparam int ST_U   = 1;
  localparam int ST_EH  = 2;
  localparam int ST_IH  = 3;

  // translation-miscellaneous flag positions
  localparam int TM_WR  = 0;
  localparam int TM_DBL = 1;

  // cause field inside the cause register
  localparam int EXC_LSB = 2;

  typedef enum logic [2:0] {
    CL_IRQ,
    CL_TMISS,
    CL_PERM,
    CL_SYNC,
    CL_BREAK,
    CL_MISALIGN,
    CL_UNKNOWN
  } exc_class_e;
endpackage

// File: rtl/exc_rst_sync.sv
module exc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/exc_cause_decode.sv
module exc_cause_decode
  import exc_entry_pkg::*;
(
  input  logic [CAUSE_W-1:0] cause_i,
  output exc_class_e         class_o
);
  always_comb begin
    unique case (cause_i)
      C_IRQ:                        class_o = CL_IRQ;
      C_TMISS:                      class_o = CL_TMISS;
      C_PERM_R, C_PERM_W, C_PERM_X: class_o = CL_PERM;
      C_SUP_A, C_SUP_I, C_SUP_D,
      C_ILLEGAL, C_TRAP:            class_o = CL_SYNC;
      C_BREAK:                      class_o = CL_BREAK;
      C_MISALIGN:                   class_o = CL_MISALIGN;
      default:                      class_o = CL_UNKNOWN;
    endcase
  end
endmodule

// File: rtl/exc_next_state.sv
module exc_next_state
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  exc_class_e         class_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    status_i,
  input  logic [XLEN-1:0]    estatus_i,
  input  logic [XLEN-1:0]    bstatus_i,
  input  logic [XLEN-1:0]    exc_i,
  input  logic [XLEN-1:0]    tlbmisc_i,
  input  logic [XLEN-1:0]    fault_addr_i,
  input  logic [XLEN-1:0]    gen_vec_i,
  input  logic [XLEN-1:0]    tmiss_vec_i,
  input  logic [XLEN-1:0]    ea_q_i,
  input  logic [XLEN-1:0]    ba_q_i,
  input  logic [XLEN-1:0]    badaddr_q_i,
  output logic [XLEN-1:0]    pc_d,
  output logic [XLEN-1:0]    status_d,
  output logic [XLEN-1:0]    estatus_d,
  output logic [XLEN-1:0]    bstatus_d,
  output logic [XLEN-1:0]    exc_d,
  output logic [XLEN-1:0]    tlbmisc_d,
  output logic [XLEN-1:0]    ea_d,
  output logic [XLEN-1:0]    ba_d,
  output logic [XLEN-1:0]    badaddr_d
);
  localparam logic [XLEN-1:0] FIELD_MASK =
    {{(XLEN-CAUSE_W){1'b0}}, {CAUSE_W{1'b1}}} << EXC_LSB;

  logic [XLEN-1:0] cause_field;
  logic [XLEN-1:0] ret_addr;
  logic [XLEN-1:0] st_entered;
  logic            in_handler;

  assign cause_field = {{(XLEN-CAUSE_W){1'b0}}, cause_i} << EXC_LSB;
  assign ret_addr    = pc_i + XLEN'(4);
  assign in_handler  = status_i[ST_EH];

  always_comb begin
    st_entered         = status_i;
    st_entered[ST_EH]  = 1'b1;
    st_entered[ST_PIE] = 1'b0;
    st_entered[ST_U]   = 1'b0;
  end

  always_comb begin
    pc_d      = gen_vec_i;
    status_d  = st_entered;
    estatus_d = estatus_i;
    bstatus_d = bstatus_i;
    exc_d     = (exc_i & ~FIELD_MASK) | cause_field;
    tlbmisc_d = tlbmisc_i;
    ea_d      = ea_q_i;
    ba_d      = ba_q_i;
    badaddr_d = badaddr_q_i;
    unique case (class_i)
      CL_IRQ: begin
        status_d          = status_i;
        status_d[ST_IH]   = 1'b1;
        status_d[ST_PIE]  = 1'b0;
        status_d[ST_U]    = 1'b0;
        estatus_d         = status_i;
        ea_d              = ret_addr;
      end
      CL_TMISS: begin
        if (in_handler) begin
          tlbmisc_d[TM_DBL] = 1'b1;
        end else begin
          estatus_d         = status_i;
          tlbmisc_d[TM_DBL] = 1'b0;
          tlbmisc_d[TM_WR]  = 1'b1;
          ea_d              = ret_addr;
          pc_d              = tmiss_vec_i;
        end
      end
      CL_PERM: begin
        estatus_d = status_i;
        ea_d      = ret_addr;
      end
      CL_SYNC: begin
        if (!in_handler) begin
          estatus_d = status_i;
          ea_d      = ret_addr;
        end
      end
      CL_BREAK: begin
        if (!in_handler) begin
          bstatus_d = status_i;
          ba_d      = ret_addr;
        end
      end
      CL_MISALIGN: begin
        pc_d      = pc_i;
        status_d  = status_i;
        exc_d     = cause_field;
        badaddr_d = fault_addr_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VEC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_valid_i,
  input  logic [4:0]      exc_cause_i,
  input  logic [XLEN-1:0] cur_pc_i,
  input  logic [XLEN-1:0] cur_status_i,
  input  logic [XLEN-1:0] cur_estatus_i,
  input  logic [XLEN-1:0] cur_bstatus_i,
  input  logic [XLEN-1:0] cur_exc_i,
  input  logic [XLEN-1:0] cur_tlbmisc_i,
  input  logic [XLEN-1:0] fault_addr_i,
  input  logic [XLEN-1:0] gen_vector_i,
  input  logic [XLEN-1:0] tlbmiss_vector_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] status_o,
  output logic [XLEN-1:0] estatus_o,
  output logic [XLEN-1:0] bstatus_o,
  output logic [XLEN-1:0] exc_o,
  output logic [XLEN-1:0] tlbmisc_o,
  output logic [XLEN-1:0] ea_o,
  output logic [XLEN-1:0] ba_o,
  output logic [XLEN-1:0] badaddr_o,
  output logic            abort_o
);
  logic       srst_n;
  exc_class_e cls;
  logic       commit_en;
  logic       abort_d;

  logic [XLEN-1:0] pc_d, status_d, estatus_d, bstatus_d, exc_d;
  logic [XLEN-1:0] tlbmisc_d, ea_d, ba_d, badaddr_d;

  exc_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  exc_cause_decode u_dec (
    .cause_i (exc_cause_i),
    .class_o (cls)
  );

  exc_next_state #(.XLEN(XLEN)) u_nxt (
    .class_i      (cls),
    .cause_i      (exc_cause_i),
    .pc_i         (cur_pc_i),
    .status_i     (cur_status_i),
    .estatus_i    (cur_estatus_i),
    .bstatus_i    (cur_bstatus_i),
    .exc_i        (cur_exc_i),
    .tlbmisc_i    (cur_tlbmisc_i),
    .fault_addr_i (fault_addr_i),
    .gen_vec_i    (gen_vector_i),
    .tmiss_vec_i  (tlbmiss_vector_i),
    .ea_q_i       (ea_o),
    .ba_q_i       (ba_o),
    .badaddr_q_i  (badaddr_o),
    .pc_d         (pc_d),
    .status_d     (status_d),
    .estatus_d    (estatus_d),
    .bstatus_d    (bstatus_d),
    .exc_d        (exc_d),
    .tlbmisc_d    (tlbmisc_d),
    .ea_d         (ea_d),
    .ba_d         (ba_d),
    .badaddr_d    (badaddr_d)
  );

  assign commit_en = exc_valid_i && (cls != CL_UNKNOWN);
  assign abort_d   = exc_valid_i && (cls == CL_UNKNOWN);

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pc_o      <= RESET_VEC;
      status_o  <= '0;
      estatus_o <= '0;
      bstatus_o <= '0;
      exc_o     <= '0;
      tlbmisc_o <= '0;
      ea_o      <= '0;
      ba_o      <= '0;
      badaddr_o <= '0;
    end else if (commit_en) begin
      pc_o      <= pc_d;
      status_o  <= status_d;
      estatus_o <= estatus_d;
      bstatus_o <= bstatus_d;
      exc_o     <= exc_d;
      tlbmisc_o <= tlbmisc_d;
      ea_o      <= ea_d;
      ba_o      <= ba_d;
      badaddr_o <= badaddr_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) abort_o <= 1'b0;
    else         abort_o <= abort_d;
  end

  // R2: no strobe means nothing moves
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!srst_n)
    !$past(exc_valid_i) |-> $stable(pc_o) && $stable(status_o) &&
      $stable(ea_o) && $stable(badaddr_o) && !abort_o);

  // R6: second miss inside a handler goes to the general vector
  p_double_miss_r6: assert property (@(posedge clk) disable iff (!srst_n)
    exc_valid_i && exc_cause_i == C_TMISS && cur_status_i[ST_EH]
      |=> tlbmisc_o[TM_DBL] && pc_o == $past(gen_vector_i) && $stable(ea_o));

  // R8: synchronous causes always leave the core inside a handler
  p_sync_enter_r8: assert property (@(posedge clk) disable iff (!srst_n)
    exc_valid_i && exc_cause_i >= C_SUP_A && exc_cause_i <= C_TRAP
      |=> status_o[ST_EH] && !status_o[ST_PIE] && !status_o[ST_U]);

  // R9: break never touches the exception-return pair
  p_break_ea_r9: assert property (@(posedge clk) disable iff (!srst_n)
    exc_valid_i && exc_cause_i == C_BREAK
      |=> $stable(ea_o) && estatus_o == $past(cur_estatus_i));

  // R11: an abort cycle leaves every register as it was
  p_abort_hold_r11: assert property (@(posedge clk) disable iff (!srst_n)
    abort_o |-> $stable(pc_o) && $stable(status_o) && $stable(exc_o) &&
      $stable(tlbmisc_o) && $stable(ba_o));
endmodule

// File: tb/exc_entry_seq_test.sv
`timescale 1ns/1ps
module exc_entry_seq_test;
  localparam int          XLEN = 32;
  localparam logic [31:0] RVEC = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        v;
  logic [4:0]  cause;
  logic [31:0] pc, st, est, bst, exr, tm, fa, gv, tv;
  logic [31:0] pc_o, status_o, estatus_o, bstatus_o, exc_o, tlbmisc_o;
  logic [31:0] ea_o, ba_o, badaddr_o;
  logic        abort_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] pc, st, est, bst, exc, tm, ea, ba, bad;
    logic        abort;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t m;

  always #2 clk = ~clk;

  exc_entry_seq #(.XLEN(XLEN), .RESET_VEC(RVEC)) uut (
    .clk(clk), .rst_n(rst_n), .exc_valid_i(v), .exc_cause_i(cause),
    .cur_pc_i(pc), .cur_status_i(st), .cur_estatus_i(est),
    .cur_bstatus_i(bst), .cur_exc_i(exr), .cur_tlbmisc_i(tm),
    .fault_addr_i(fa), .gen_vector_i(gv), .tlbmiss_vector_i(tv),
    .pc_o(pc_o), .status_o(status_o), .estatus_o(estatus_o),
    .bstatus_o(bstatus_o), .exc_o(exc_o), .tlbmisc_o(tlbmisc_o),
    .ea_o(ea_o), .ba_o(ba_o), .badaddr_o(badaddr_o), .abort_o(abort_o));

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(exp_t e);
    chk(e.tag, "pc", pc_o, e.pc);
    chk(e.tag, "status", status_o, e.st);
    chk(e.tag, "estatus", estatus_o, e.est);
    chk(e.tag, "bstatus", bstatus_o, e.bst);
    chk(e.tag, "exc", exc_o, e.exc);
    chk(e.tag, "tlbmisc", tlbmisc_o, e.tm);
    chk(e.tag, "ea", ea_o, e.ea);
    chk(e.tag, "ba", ba_o, e.ba);
    chk(e.tag, "badaddr", badaddr_o, e.bad);
    chk(e.tag, "abort", {31'd0, abort_o}, {31'd0, e.abort});
  endtask

  // monitor: compares one expected item per cycle after it is queued
  always @(negedge clk) begin
    if (q.size() > 0) compare(q.pop_front());
  end

  function automatic logic [31:0] entered(logic [31:0] s);
    return (s | 32'h4) & ~32'h3;
  endfunction

  task automatic drive(logic vv, logic [4:0] c, logic [31:0] p, logic [31:0] s,
                       logic [31:0] es, logic [31:0] bs, logic [31:0] ex,
                       logic [31:0] t, logic [31:0] f, string tag);
    exp_t e;
    @(negedge clk);
    v = vv; cause = c; pc = p; st = s; est = es; bst = bs; exr = ex; tm = t; fa = f;
    @(posedge clk);
    #1;
    e = m;
    e.abort = 1'b0;
    e.tag = tag;
    if (vv) begin
      if (c == 0 || c > 12) begin
        e.abort = 1'b1;
      end else if (c == 12) begin
        e.pc = p; e.st = s; e.est = es; e.bst = bs; e.tm = t;
        e.exc = {25'd0, c, 2'b00};
        e.bad = f;
      end else begin
        e.pc = gv; e.st = entered(s); e.est = es; e.bst = bs; e.tm = t;
        e.exc = (ex & ~32'h7c) | {25'd0, c, 2'b00};
        if (c == 1) begin
          e.st = (s | 32'h8) & ~32'h3; e.est = s; e.ea = p + 4;
        end else if (c == 2) begin
          if (!s[2]) begin
            e.est = s; e.tm = (t & ~32'h2) | 32'h1; e.ea = p + 4; e.pc = tv;
          end else begin
            e.tm = t | 32'h2;
          end
        end else if (c <= 5) begin
          e.est = s; e.ea = p + 4;
        end else if (c <= 10) begin
          if (!s[2]) begin e.est = s; e.ea = p + 4; end
        end else begin
          if (!s[2]) begin e.bst = s; e.ba = p + 4; end
        end
      end
    end
    v = 1'b0;
    m = e;
    q.push_back(e);
  endtask

  initial begin
    #(4 * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    exp_t r;
    rst_n = 1'b0; v = 1'b0; cause = '0;
    pc = '0; st = '0; est = '0; bst = '0; exr = '0; tm = '0; fa = '0;
    gv = 32'h0000_0820; tv = 32'h0000_0A40;
    r.pc = RVEC; r.st = '0; r.est = '0; r.bst = '0; r.exc = '0; r.tm = '0;
    r.ea = '0; r.ba = '0; r.bad = '0; r.abort = 1'b0; r.tag = "R1";
    m = r;
    repeat (3) @(negedge clk);
    compare(r);                                  // R1 during reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare(r);                                  // R1 after release

    // R2: idle cycles with noisy inputs change nothing
    drive(0, 5'd1, 32'h1111_0000, 32'h5, 32'h6, 32'h7, 32'hffff_ffff, 32'h3, 32'h99, "R2");
    drive(0, 5'd12, 32'h2222_0000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h55, "R2");

    // R4 / R3: interrupt with marker bits in the cause register
    drive(1, 5'd1, 32'h0000_4000, 32'h0000_0011, 32'hAA, 32'hBB, 32'hF000_0003, 32'h8000_0000, 0, "R4");
    // R5: first miss, double flag pre-set must be cleared
    drive(1, 5'd2, 32'h0000_5000, 32'h0000_0003, 32'h1, 32'h2, 32'h0000_007C, 32'hC000_0002, 0, "R5");
    // R6: miss inside handler
    drive(1, 5'd2, 32'h0000_6000, 32'h0000_0007, 32'h1234, 32'h2, 32'h0, 32'hC000_0001, 0, "R6");
    // R7: permission faults with EH clear and set
    drive(1, 5'd3, 32'h0000_7000, 32'h0000_0001, 32'h9, 32'h8, 32'h100, 32'h4, 0, "R7");
    drive(1, 5'd4, 32'h0000_7100, 32'h0000_0006, 32'h9, 32'h8, 32'h0, 32'h4, 0, "R7");
    drive(1, 5'd5, 32'h0000_7200, 32'h0000_0004, 32'h9, 32'h8, 32'h0, 32'h4, 0, "R7");
    // R8: sync causes, EH clear then set
    drive(1, 5'd6, 32'h0000_8000, 32'h0000_0003, 32'h77, 32'h8, 32'h0, 32'h0, 0, "R8");
    drive(1, 5'd7, 32'h0000_8100, 32'h0000_0007, 32'h77, 32'h8, 32'h0, 32'h0, 0, "R8");
    drive(1, 5'd9, 32'h0000_8200, 32'h0000_0005, 32'h66, 32'h8, 32'h0, 32'h0, 0, "R8");
    drive(1, 5'd10, 32'h0000_8300, 32'h0000_0001, 32'h66, 32'h8, 32'h0, 32'h0, 0, "R8");
    drive(1, 5'd8, 32'h0000_8400, 32'h0000_0004, 32'h66, 32'h8, 32'h0, 32'h0, 0, "R8");
    // R9: break, EH clear then set
    drive(1, 5'd11, 32'h0000_9000, 32'h0000_0003, 32'h44, 32'h55, 32'h0, 32'h0, 0, "R9");
    drive(1, 5'd11, 32'h0000_9100, 32'h0000_0004, 32'h44, 32'h55, 32'h0, 32'h0, 0, "R9");
    // R10: misaligned access
    drive(1, 5'd12, 32'h0000_A000, 32'h0000_0005, 32'h31, 32'h32, 32'hFFFF_FF83, 32'h3, 32'hDEAD_BEE1, "R10");
    // R11: unknown causes abort, then the flag drops
    drive(1, 5'd0, 32'h0000_B000, 32'h1, 32'h1, 32'h1, 32'h1, 32'h1, 32'h1, "R11");
    drive(1, 5'd20, 32'h0000_B100, 32'h1, 32'h1, 32'h1, 32'h1, 32'h1, 32'h1, "R11");
    drive(0, 5'd0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, "R11");
    // R3: field replacement keeps surrounding bits after abort
    drive(1, 5'd10, 32'h0000_C000, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0, 0, "R3");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule